// File: doc/BRIEF.md
# Configurable DSSS Chip Spreader

This block sits in the transmit path of a direct-sequence spread-spectrum link. It takes data bits one at a time over a valid/ready handshake and replaces each bit, or each pair of bits, with a run of pseudo-noise chips drawn from a single 64-bit code word. Chips leave the block one at a time, paced by a chip-enable tick from the surrounding timing logic. The next chip goes out on each tick, and a one-cycle valid strobe marks it.

A 3-bit mode input chooses the spreading. Bit 2 picks the chip count per symbol: 1 gives 32 chips and 0 gives 64. Bit 1 picks double rate, which is only legal with 32 chips. Bit 0 picks the receive oversampling and has no effect on the chips. In 32-chip modes the 64-bit code word serves as two 32-chip codes. Some mode codes are illegal. While one of them is applied, the block raises an error flag and stops all progress. A mode change takes effect only at a symbol boundary.

Top module: `dsss_spreader`

## Requirements
- R1: During and after reset, chip_valid_o and chip_o are 0 and the stored mode is 000. With a legal mode applied and no symbol in progress, bit_ready_o is 1.
- R2: mode_err_o is 1 exactly while mode_i is 001, 010, 011 or 111. For every other value it is 0.
- R3: While mode_err_o is 1, bit_ready_o is 0 and no chip is emitted. A symbol in progress pauses and resumes once the mode becomes legal.
- R4: With mode 000, an accepted bit of 1 sends code_i[63] down to code_i[0], one chip per tick. A bit of 0 sends the inverse of each of those chips. The code is captured on the clock at which the symbol starts.
- R5: With mode 100 or 101, a bit of 1 sends code_i[63:32] and a bit of 0 sends code_i[31:0], most significant chip first, for 32 chips.
- R6: With mode 110, each symbol takes two accepted bits. The first bit picks code_i[63:32] (1) or code_i[31:0] (0). The second bit sends that half as it is (1) or inverted (0), for 32 chips.
- R7: bit_ready_o is 1 only while no symbol's chips remain to be sent.
- R8: The mode is taken at the acceptance of the first or only bit of a symbol. A change to mode_i between the two bits of a pair, or while chips are going out, does not alter that symbol.
- R9: While chip_valid_o is 0, chip_o keeps its previous value.
- R10: Each chip_valid_o pulse follows a clock at which chip_en_i was 1 and the mode was legal. Each such tick sends at most one chip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Spreading mode: bit 2 selects 32 chips, bit 1 selects double rate, bit 0 selects oversampling (no effect on chips) |
| code_i | input | 64 | PN code word, captured at symbol start |
| bit_valid_i | input | 1 | Data bit offered |
| bit_data_i | input | 1 | Data bit value |
| bit_ready_o | output | 1 | Block accepts the offered bit on this clock |
| chip_en_i | input | 1 | Chip-rate tick |
| chip_o | output | 1 | Current chip, held between strobes |
| chip_valid_o | output | 1 | One-cycle strobe for a newly emitted chip |
| mode_err_o | output | 1 | The applied mode value is illegal |

## Verification
The assertions assume that mode_i, chip_en_i and the handshake inputs are synchronous to clk and settle well before each rising edge. They also assume that reset is held for at least one edge before anything is checked. The bench changes every input one time unit after a rising edge and reads outputs at the falling edge. Illegal modes are applied for single random cycles in the middle of symbols and between the two bits of a pair, so the pause and resume paths stay within these assumptions. A reference model records each accepted bit together with the mode and code seen on that clock. It then predicts the chip sequence from the stated rules and checks the strobe timing against the tick history.

// File: rtl/dsss_spr_pkg.sv
// Package: shared mode encodings and the illegal-mode decode for the spreader.
// Assumes a 3-bit mode: [2] narrow (32 chips), [1] dual (two bits per symbol),
// [0] oversampling choice that the spreader itself ignores.
package dsss_spr_pkg;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_WIDE   = 3'b000;
    localparam logic [MODE_W-1:0] MODE_NARROW = 3'b100;
    localparam logic [MODE_W-1:0] MODE_DUAL   = 3'b110;

    // True for mode values that must halt the spreader.
    function automatic logic mode_illegal(input logic [MODE_W-1:0] m);
        return (m == 3'b001) || (m == 3'b010) || (m == 3'b011) || (m == 3'b111);
    endfunction
endpackage

// File: rtl/spr_mode_ctl.sv
// Module: holds the mode that governs the symbol in progress and flags illegal
// values. At a boundary the requested mode passes straight through; otherwise
// the value latched at the last boundary applies.
// Assumes mode_req is synchronous to clk.
module spr_mode_ctl
    import dsss_spr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_req,
    input  logic              boundary,
    output logic              eff_narrow,
    output logic              eff_dual,
    output logic              illegal
);
    logic held_narrow;
    logic held_dual;

    assign illegal = mode_illegal(mode_req);

    // Latch the mode whenever a legal value is seen at a symbol boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_narrow <= MODE_WIDE[2];
            held_dual   <= MODE_WIDE[1];
        end else if (boundary && !illegal) begin
            held_narrow <= mode_req[2];
            held_dual   <= mode_req[1];
        end
    end

    // Choose between the live request and the held mode.
    always_comb begin
        eff_narrow = boundary ? mode_req[2] : held_narrow;
        eff_dual   = boundary ? mode_req[1] : held_dual;
    end
endmodule

// File: rtl/spr_symbol_build.sv
// Module: combinational builder of one symbol's chip pattern, left-aligned so
// the first chip sits at the MSB, plus the symbol's chip count.
// Assumes dual is only set together with narrow (legal modes).
module spr_symbol_build #(
    parameter int CODE_W = 64,
    parameter int CNT_W  = $clog2(CODE_W + 1)
) (
    input  logic [CODE_W-1:0] code,
    input  logic              narrow,
    input  logic              dual,
    input  logic              first_bit,
    input  logic              data_bit,
    output logic [CODE_W-1:0] pattern,
    output logic [CNT_W-1:0]  len
);
    localparam int HALF = CODE_W / 2;

    logic [HALF-1:0] half_sel;
    logic            half_pick;
    logic            polarity;

    // Select the half and polarity for narrow symbols, or the whole code for wide ones.
    always_comb begin
        half_pick = dual ? first_bit : data_bit;
        polarity  = dual ? data_bit : 1'b1;
        half_sel  = half_pick ? code[CODE_W-1 -: HALF] : code[HALF-1:0];
        if (narrow) begin
            pattern = {(polarity ? half_sel : ~half_sel), {HALF{1'b0}}};
            len     = CNT_W'(HALF);
        end else begin
            pattern = data_bit ? code : ~code;
            len     = CNT_W'(CODE_W);
        end
    end
endmodule

// File: rtl/spr_chip_shifter.sv
// Module: shifts a loaded pattern out MSB first, one chip per step, and counts
// the chips still owed. busy stays high until the last chip has gone out.
// Assumes load is only raised while busy is low.
module spr_chip_shifter #(
    parameter int CODE_W = 64,
    parameter int CNT_W  = $clog2(CODE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] pattern,
    input  logic [CNT_W-1:0]  len,
    input  logic              step,
    output logic              busy,
    output logic              chip,
    output logic              chip_valid
);
    logic [CODE_W-1:0] pat_q;
    logic [CNT_W-1:0]  left_q;

    assign busy = (left_q != '0);

    // Load a new symbol or emit one chip per permitted step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q      <= '0;
            left_q     <= '0;
            chip       <= 1'b0;
            chip_valid <= 1'b0;
        end else begin
            chip_valid <= 1'b0;
            if (load) begin
                pat_q  <= pattern;
                left_q <= len;
            end else if (step && busy) begin
                chip       <= pat_q[CODE_W-1];
                pat_q      <= {pat_q[CODE_W-2:0], 1'b0};
                left_q     <= left_q - CNT_W'(1);
                chip_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsss_spreader.sv
// Module: top of the DSSS chip spreader. Accepts data bits, pairs them in
// double-rate mode, builds each symbol's chips and sends them on chip ticks.
// Assumes all inputs are synchronous to clk; reset is synchronous active-low.
module dsss_spreader
    import dsss_spr_pkg::*;
#(
    parameter int CODE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              bit_valid_i,
    input  logic              bit_data_i,
    output logic              bit_ready_o,
    input  logic              chip_en_i,
    output logic              chip_o,
    output logic              chip_valid_o,
    output logic              mode_err_o
);
    localparam int CNT_W = $clog2(CODE_W + 1);

    logic              busy;
    logic              pair_open;
    logic              pair_first;
    logic              boundary;
    logic              eff_narrow;
    logic              eff_dual;
    logic              illegal;
    logic              accept;
    logic              launch;
    logic [CODE_W-1:0] pattern;
    logic [CNT_W-1:0]  len;

    assign boundary    = !busy && !pair_open;
    assign bit_ready_o = !busy && !illegal;
    assign accept      = bit_valid_i && bit_ready_o;
    assign launch      = accept && (!eff_dual || pair_open);
    assign mode_err_o  = illegal;

    spr_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_req   (mode_i),
        .boundary   (boundary),
        .eff_narrow (eff_narrow),
        .eff_dual   (eff_dual),
        .illegal    (illegal)
    );

    // Hold the first bit of a double-rate pair until its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_open  <= 1'b0;
            pair_first <= 1'b0;
        end else if (accept && eff_dual && !pair_open) begin
            pair_open  <= 1'b1;
            pair_first <= bit_data_i;
        end else if (launch) begin
            pair_open  <= 1'b0;
        end
    end

    spr_symbol_build #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_build (
        .code      (code_i),
        .narrow    (eff_narrow),
        .dual      (eff_dual),
        .first_bit (pair_first),
        .data_bit  (bit_data_i),
        .pattern   (pattern),
        .len       (len)
    );

    spr_chip_shifter #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (launch),
        .pattern    (pattern),
        .len        (len),
        .step       (chip_en_i && !illegal),
        .busy       (busy),
        .chip       (chip_o),
        .chip_valid (chip_valid_o)
    );
endmodule

// File: rtl/dsss_spreader_chk.sv
// Module: property checker for dsss_spreader, attached with bind below.
// Assumes it observes the top's ports only.
module dsss_spreader_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_ready_o,
    input logic chip_en_i,
    input logic chip_o,
    input logic chip_valid_o,
    input logic mode_err_o
);
    // R3
    no_ready_when_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> !bit_ready_o);

    // R10
    chip_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_valid_o |-> $past(chip_en_i && !mode_err_o));

    // R9
    chip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_valid_o |-> $stable(chip_o));

    // R7
    ready_between_symbols_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_valid_o |-> !$past(bit_ready_o));
endmodule

bind dsss_spreader dsss_spreader_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_ready_o  (bit_ready_o),
    .chip_en_i    (chip_en_i),
    .chip_o       (chip_o),
    .chip_valid_o (chip_valid_o),
    .mode_err_o   (mode_err_o)
);

// File: tb/dsss_spreader_test.sv
// Bench: behavioural queue model of the chip stream, compared every clock.
module dsss_spreader_test;
    localparam int CW = 64;
    localparam int HW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode_i = 3'b000;
    logic [CW-1:0] code_i = {32'hC3A5_1E0F, 32'h96F0_5A3C};
    logic          bit_valid_i = 1'b0;
    logic          bit_data_i = 1'b0;
    logic          chip_en_i = 1'b0;
    logic          bit_ready_o;
    logic          chip_o;
    logic          chip_valid_o;
    logic          mode_err_o;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    exp_q[$];
    string tag_q[$];
    bit    pend = 1'b0;
    bit    pend_first = 1'b0;
    bit    last_emit_ok = 1'b0;
    logic  prev_chip = 1'b0;

    always #4 clk = ~clk;

    dsss_spreader uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .code_i       (code_i),
        .bit_valid_i  (bit_valid_i),
        .bit_data_i   (bit_data_i),
        .bit_ready_o  (bit_ready_o),
        .chip_en_i    (chip_en_i),
        .chip_o       (chip_o),
        .chip_valid_o (chip_valid_o),
        .mode_err_o   (mode_err_o)
    );

    function automatic bit is_bad(input logic [2:0] m);
        return m == 3'd1 || m == 3'd2 || m == 3'd3 || m == 3'd7;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Model of one accepted bit: pushes the chips the requirements predict.
    task automatic model_accept();
        logic [HW-1:0] h;
        if (pend) begin
            h = pend_first ? code_i[CW-1:HW] : code_i[HW-1:0];
            for (int i = HW - 1; i >= 0; i--) begin
                exp_q.push_back(bit_data_i ? h[i] : ~h[i]);
                tag_q.push_back(mode_i == 3'b110 ? "R6" : "R8");
            end
            pend = 1'b0;
        end else begin
            case (mode_i)
                3'b000: for (int i = CW - 1; i >= 0; i--) begin
                    exp_q.push_back(bit_data_i ? code_i[i] : ~code_i[i]);
                    tag_q.push_back("R4");
                end
                3'b100, 3'b101: begin
                    h = bit_data_i ? code_i[CW-1:HW] : code_i[HW-1:0];
                    for (int i = HW - 1; i >= 0; i--) begin
                        exp_q.push_back(h[i]);
                        tag_q.push_back("R5");
                    end
                end
                3'b110: begin
                    pend = 1'b1;
                    pend_first = bit_data_i;
                end
                default: check(1'b0, "R3", "bit accepted under illegal mode", 1, 0);
            endcase
        end
    endtask

    // Per-cycle comparison at the falling edge.
    task automatic observe();
        bit    e;
        string t;
        if (chip_valid_o) begin
            check(last_emit_ok, "R3 R10", "chip strobe without permitted tick", 1, 0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "chip with nothing owed", 1, 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(chip_o === e, t, "chip value", chip_o, e);
            end
        end else begin
            check(chip_o === prev_chip, "R9", "chip changed without strobe", chip_o, prev_chip);
        end
        check(mode_err_o === is_bad(mode_i), "R2", "mode error flag", mode_err_o, is_bad(mode_i));
        if (is_bad(mode_i)) check(bit_ready_o === 1'b0, "R3", "ready under illegal mode", bit_ready_o, 0);
        if (bit_ready_o) check(exp_q.size() == 0, "R7", "ready with chips owed", exp_q.size(), 0);
        if (bit_valid_i && bit_ready_o) model_accept();
        last_emit_ok = chip_en_i && !is_bad(mode_i);
        prev_chip = chip_o;
    endtask

    task automatic drive(input logic [2:0] base, input int en_pct, input int bad_pct,
                         input int flip_pct, input bit mix);
        logic [2:0] m;
        bit_valid_i = ($urandom % 100) < 70;
        bit_data_i  = $urandom % 2;
        chip_en_i   = ($urandom % 100) < en_pct;
        if (($urandom % 100) < 5) code_i = {$urandom, $urandom};
        m = base;
        if (mix) begin
            case ($urandom % 4)
                0: m = 3'b000;
                1: m = 3'b100;
                2: m = 3'b101;
                default: m = 3'b110;
            endcase
        end
        if (pend && ($urandom % 100) < flip_pct) m = 3'b100;
        if (($urandom % 100) < bad_pct) begin
            case ($urandom % 4)
                0: m = 3'b001;
                1: m = 3'b010;
                2: m = 3'b011;
                default: m = 3'b111;
            endcase
        end
        mode_i = m;
    endtask

    task automatic run_phase(input logic [2:0] base, input int n, input int en_pct,
                             input int bad_pct, input int flip_pct, input bit mix);
        for (int c = 0; c < n; c++) begin
            @(posedge clk);
            #1 drive(base, en_pct, bad_pct, flip_pct, mix);
            @(negedge clk);
            observe();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs idle while reset is held
        check(chip_valid_o === 1'b0, "R1", "valid in reset", chip_valid_o, 0);
        check(chip_o === 1'b0, "R1", "chip in reset", chip_o, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle and ready after reset with mode 000
        check(bit_ready_o === 1'b1, "R1", "ready after reset", bit_ready_o, 1);
        check(chip_valid_o === 1'b0, "R1", "valid after reset", chip_valid_o, 0);
        check(chip_o === 1'b0, "R1", "chip after reset", chip_o, 0);
        check(mode_err_o === 1'b0, "R1", "error after reset", mode_err_o, 0);

        run_phase(3'b000, 1500, 100, 0, 0, 1'b0);
        run_phase(3'b100, 1500, 50, 0, 0, 1'b0);
        run_phase(3'b101, 800, 100, 0, 0, 1'b0);
        run_phase(3'b110, 2500, 70, 0, 30, 1'b0);
        run_phase(3'b000, 1500, 80, 10, 0, 1'b0);
        run_phase(3'b110, 1500, 80, 10, 20, 1'b0);
        run_phase(3'b000, 3000, 60, 5, 0, 1'b1);

        // Drain: finish any open pair, then let all owed chips out.
        for (int c = 0; c < 400 && (exp_q.size() != 0 || pend); c++) begin
            @(posedge clk);
            #1;
            bit_valid_i = pend;
            bit_data_i  = 1'b1;
            chip_en_i   = 1'b1;
            mode_i      = 3'b110;
            @(negedge clk);
            observe();
        end
        @(posedge clk);
        #1 bit_valid_i = 1'b0;
        @(negedge clk);
        observe();
        check(exp_q.size() == 0, "R10", "chips still owed at end", exp_q.size(), 0);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            summary();
        end
    end
endmodule